// File: doc/BRIEF.md
# Processor Cluster Configuration Registers

This block is the register window that software uses to bring up the cores of a four-core processor cluster. It sits on a simple 32-bit register bus and decodes a 1 KiB byte-addressed window. Each request is presented for one cycle. The block answers one cycle later with read data and an error flag.

Three registers hold state that software can read and write: a general control word, a standby flag and a reset entry address. Every core has its own group of three registers: reset control, control and status. A non-zero write to a core's reset-control register produces a one-cycle start request for that core. The request carries the stored entry address and a fixed start exception level of 3. The cluster reset, system reset, clock-gating, per-core control and per-core status registers return fixed values and take no writes. The debug offset and the three 64-bit counter offsets are decoded but not implemented. They read zero and report an error.

The core groups begin at byte offset 0x40 and repeat every 0x40 bytes. Within a group the reset-control register is at +0x0, the control register at +0x4 and the status register at +0x8. The core index is therefore (offset − 0x40) >> 6.

Top module: `cluster_cfg_regs`

## Requirements
- R1: After a synchronous active-low reset, the general control register (0x184) reads 0x00000020, and the standby flag (0x1A0) and the entry address (0x1A4) read 0. No start request and no response are pending.
- R2: A full-word write to 0x184, 0x1A0 or 0x1A4 stores all 32 bits, and a later read of that offset returns them.
- R3: Fixed read values are: cluster reset (0x000) and system reset (0x140) read 0x1; each core reset control reads 0x3; each core control reads 0x0; each core status reads 0x1; clock gating (0x144) reads 0x10F. Writes to any of these leave the read value unchanged.
- R4: A full-word write of a non-zero value to offset 0x40·(i+1), for i in 0..3, sets bit i of start_req. No other bit is set. The bit is high for exactly one cycle, in the cycle after the request is accepted.
- R5: While start_req is non-zero, start_addr equals the value the entry-address register held when the triggering write was accepted. start_el always reads 3.
- R6: A write of zero to a core reset-control register produces no start request.
- R7: The debug offset 0x1E4 and the counter offsets 0x280, 0x284 and 0x288 read 0, ignore writes and set rsp_err.
- R8: Any other offset reads 0, ignores writes and sets rsp_err. This includes offsets that are not word-aligned and unused slots inside a core group.
- R9: A request whose byte enable is not 4'b1111 sets rsp_err, returns 0, changes no register and produces no start request.
- R10: rsp_valid is high exactly in the cycle after each request. rsp_rdata is 0 for writes. Reads have no side effects and never produce a start request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte offset inside the window |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables; only 4'b1111 is legal |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Access to an unimplemented or unmapped offset, or a partial access |
| start_req | output | 4 | One-hot start pulse, one bit per core |
| start_addr | output | 32 | Entry address carried by the start pulse |
| start_el | output | 2 | Exception level requested at start (constant 3) |

## Verification
The bench writes to each core's reset register with different non-zero patterns, with zero, and with a partial byte enable. A wrong index calculation would pulse the wrong core. A design that tested only the low data bits would miss a write of 0x80000000. A design that did not gate on byte enables would start a core on a one-byte write. The bench rewrites the entry address just before a start write, then checks that the pulse carries the new value, so a stale or late capture shows up. It also writes to the fixed and unimplemented registers and then reads them back. This exposes a decoder that lets such writes leak into the stored registers. Misaligned offsets and holes inside a core group must report an error instead of aliasing onto a neighbouring register.

// File: rtl/cluster_cfg_pkg.sv
// Package: cluster_cfg_pkg
// Shared register offsets, fixed read values and the decoded-region type
// for the cluster configuration window. Offsets are byte offsets into a
// 1 KiB window; only word-aligned offsets decode to a register.
package cluster_cfg_pkg;

    // Decoded target of an access.
    typedef enum logic [3:0] {
        RG_NONE,        // unmapped offset
        RG_CLUSTER_RST, // fixed cluster reset word
        RG_CORE_RST,    // per-core reset control (start trigger)
        RG_CORE_CTRL,   // per-core control, fixed
        RG_CORE_STAT,   // per-core status, fixed
        RG_SYS_RST,     // fixed system reset word
        RG_GATE,        // fixed clock gating word
        RG_GEN,         // general control, read/write
        RG_STBY,        // standby flag, read/write
        RG_ENTRY,       // entry address, read/write
        RG_UNIMP        // decoded but not implemented
    } region_e;

    // Offsets outside the per-core groups.
    localparam logic [9:0] OFS_CLUSTER_RST = 10'h000;
    localparam logic [9:0] OFS_SYS_RST     = 10'h140;
    localparam logic [9:0] OFS_GATE        = 10'h144;
    localparam logic [9:0] OFS_GEN         = 10'h184;
    localparam logic [9:0] OFS_STBY        = 10'h1A0;
    localparam logic [9:0] OFS_ENTRY       = 10'h1A4;
    localparam logic [9:0] OFS_DEBUG       = 10'h1E4;
    localparam logic [9:0] OFS_CNT_CTRL    = 10'h280;
    localparam logic [9:0] OFS_CNT_LO      = 10'h284;
    localparam logic [9:0] OFS_CNT_HI      = 10'h288;

    // Position of each register inside a core group.
    localparam logic [5:0] SUB_RST  = 6'h00;
    localparam logic [5:0] SUB_CTRL = 6'h04;
    localparam logic [5:0] SUB_STAT = 6'h08;

    // Fixed read values.
    localparam logic [31:0] VAL_CLUSTER_RST = 32'h0000_0001;
    localparam logic [31:0] VAL_SYS_RST     = 32'h0000_0001;
    localparam logic [31:0] VAL_CORE_RST    = 32'h0000_0003;
    localparam logic [31:0] VAL_CORE_CTRL   = 32'h0000_0000;
    localparam logic [31:0] VAL_CORE_STAT   = 32'h0000_0001;
    localparam logic [31:0] VAL_GATE        = 32'h0000_010F;

    // Reset values of the read/write registers.
    localparam logic [31:0] RST_GEN   = 32'h0000_0020;
    localparam logic [31:0] RST_STBY  = 32'h0000_0000;
    localparam logic [31:0] RST_ENTRY = 32'h0000_0000;

endpackage

// File: rtl/cfg_addr_decode.sv
// Module: cfg_addr_decode
// Maps a byte offset to a register region and, for per-core registers,
// to a core index. Purely combinational.
// Assumes: core groups occupy 64-byte slots starting at slot 1 (offset 0x40),
// so NUM_CORES must not exceed 4 or the groups would overlap offset 0x140.
module cfg_addr_decode
    import cluster_cfg_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int NUM_CORES = 4,
    parameter int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output region_e           region_o,
    output logic [CORE_W-1:0] core_o
);

    localparam int SLOT_W = ADDR_W - 6;

    logic [SLOT_W-1:0]    slot;
    logic [5:0]           sub;
    logic [NUM_CORES-1:0] core_hit;

    assign slot = addr_i[ADDR_W-1:6];
    assign sub  = addr_i[5:0];

    // One slot comparator per core; core c lives in slot c+1.
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core_hit
        assign core_hit[c] = (slot == SLOT_W'(c + 1));
    end

    // Core index is the slot number less one, i.e. (offset - 0x40) >> 6.
    assign core_o = CORE_W'(slot - SLOT_W'(1));

    // Region select: per-core groups first, then the fixed offsets.
    always_comb begin
        region_o = RG_NONE;
        if (|core_hit) begin
            unique case (sub)
                SUB_RST:  region_o = RG_CORE_RST;
                SUB_CTRL: region_o = RG_CORE_CTRL;
                SUB_STAT: region_o = RG_CORE_STAT;
                default:  region_o = RG_NONE;
            endcase
        end else begin
            case (10'(addr_i))
                OFS_CLUSTER_RST: region_o = RG_CLUSTER_RST;
                OFS_SYS_RST:     region_o = RG_SYS_RST;
                OFS_GATE:        region_o = RG_GATE;
                OFS_GEN:         region_o = RG_GEN;
                OFS_STBY:        region_o = RG_STBY;
                OFS_ENTRY:       region_o = RG_ENTRY;
                OFS_DEBUG,
                OFS_CNT_CTRL,
                OFS_CNT_LO,
                OFS_CNT_HI:      region_o = RG_UNIMP;
                default:         region_o = RG_NONE;
            endcase
        end
    end

    // R8: a misaligned offset never decodes to a register.
    always_comb begin
        if (addr_i[1:0] != 2'b00)
            a_r8_misaligned_unmapped: assert (region_o == RG_NONE);
    end

endmodule

// File: rtl/cfg_regfile.sv
// Module: cfg_regfile
// Holds the three software read/write registers: general control,
// standby flag and entry address.
// Assumes: wr_en_i is already qualified (valid, full byte enable, write).
module cfg_regfile
    import cluster_cfg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  region_e           region_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] gen_q,
    output logic [DATA_W-1:0] stby_q,
    output logic [DATA_W-1:0] entry_q
);

    logic wr_gen, wr_stby, wr_entry;

    assign wr_gen   = wr_en_i && (region_i == RG_GEN);
    assign wr_stby  = wr_en_i && (region_i == RG_STBY);
    assign wr_entry = wr_en_i && (region_i == RG_ENTRY);

    // General control register, resets to its documented default.
    always_ff @(posedge clk) begin
        if (!rst_n)      gen_q <= DATA_W'(RST_GEN);
        else if (wr_gen) gen_q <= wdata_i;
    end

    // Standby flag register.
    always_ff @(posedge clk) begin
        if (!rst_n)       stby_q <= DATA_W'(RST_STBY);
        else if (wr_stby) stby_q <= wdata_i;
    end

    // Entry address used by core start requests.
    always_ff @(posedge clk) begin
        if (!rst_n)        entry_q <= DATA_W'(RST_ENTRY);
        else if (wr_entry) entry_q <= wdata_i;
    end

    // R2: registers only change when their own write strobe fires.
    a_r2_gen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_gen |=> $stable(gen_q));
    a_r2_stby_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stby |=> $stable(stby_q));
    a_r2_entry_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_entry |=> $stable(entry_q));
    // R2: a write lands in full.
    a_r2_entry_store: assert property (@(posedge clk) disable iff (!rst_n)
        wr_entry |=> entry_q == $past(wdata_i));

endmodule

// File: rtl/cfg_start_pulse.sv
// Module: cfg_start_pulse
// Turns a non-zero write to a core's reset-control register into a
// one-cycle start pulse for that core, and captures the entry address
// that travels with it.
// Assumes: fire_i is already qualified (full-word write to a core reset).
module cfg_start_pulse #(
    parameter int NUM_CORES = 4,
    parameter int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    parameter int DATA_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fire_i,
    input  logic [CORE_W-1:0]    core_i,
    input  logic [DATA_W-1:0]    wdata_i,
    input  logic [DATA_W-1:0]    entry_i,
    output logic [NUM_CORES-1:0] start_req,
    output logic [DATA_W-1:0]    start_addr
);

    logic launch;

    assign launch = fire_i && (wdata_i != '0);

    // One pulse flop per core; only the addressed core fires.
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_pulse
        always_ff @(posedge clk) begin
            if (!rst_n) start_req[c] <= 1'b0;
            else        start_req[c] <= launch && (core_i == CORE_W'(c));
        end
    end

    // Capture the entry address that accompanies the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)      start_addr <= '0;
        else if (launch) start_addr <= entry_i;
    end

    // R4: at most one core is started at a time.
    a_r4_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(start_req));
    // R5: the pulse carries the entry address of the launching cycle.
    a_r5_addr_captured: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req != '0) |-> start_addr == $past(entry_i));
    // R6: a zero write never starts a core.
    a_r6_zero_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && wdata_i == '0) |=> start_req == '0);

endmodule

// File: rtl/cluster_cfg_regs.sv
// Module: cluster_cfg_regs (top)
// Configuration register window for a multi-core cluster. Accepts one
// 32-bit request per cycle and answers in the next cycle with read data
// and an error flag. Drives one-cycle core start pulses.
// Assumes: requests are single-cycle; only full-word byte enables are legal.
module cluster_cfg_regs
    import cluster_cfg_pkg::*;
#(
    parameter int          ADDR_W    = 10,
    parameter int          DATA_W    = 32,
    parameter int          NUM_CORES = 4,
    parameter logic [1:0]  START_EL  = 2'd3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [DATA_W/8-1:0]  req_be,
    output logic                 rsp_valid,
    output logic [DATA_W-1:0]    rsp_rdata,
    output logic                 rsp_err,
    output logic [NUM_CORES-1:0] start_req,
    output logic [DATA_W-1:0]    start_addr,
    output logic [1:0]           start_el
);

    localparam int BE_W   = DATA_W / 8;
    localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

    region_e           region;
    logic [CORE_W-1:0] core_idx;
    logic              full_word;
    logic              bad_target;
    logic              wr_en;
    logic              fire;
    logic              rd_ok;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] gen_q, stby_q, entry_q;

    cfg_addr_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_CORES(NUM_CORES),
        .CORE_W   (CORE_W)
    ) u_decode (
        .addr_i  (req_addr),
        .region_o(region),
        .core_o  (core_idx)
    );

    // Qualify the request: full byte enable and a real register behind it.
    assign full_word  = (req_be == {BE_W{1'b1}});
    assign bad_target = (region == RG_NONE) || (region == RG_UNIMP);
    assign wr_en      = req_valid && req_write && full_word && !bad_target;
    assign fire       = wr_en && (region == RG_CORE_RST);
    assign rd_ok      = req_valid && !req_write && full_word && !bad_target;

    cfg_regfile #(
        .DATA_W(DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (wr_en),
        .region_i(region),
        .wdata_i (req_wdata),
        .gen_q   (gen_q),
        .stby_q  (stby_q),
        .entry_q (entry_q)
    );

    cfg_start_pulse #(
        .NUM_CORES(NUM_CORES),
        .CORE_W   (CORE_W),
        .DATA_W   (DATA_W)
    ) u_start (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire_i    (fire),
        .core_i    (core_idx),
        .wdata_i   (req_wdata),
        .entry_i   (entry_q),
        .start_req (start_req),
        .start_addr(start_addr)
    );

    // Read data select by decoded region.
    always_comb begin
        unique case (region)
            RG_CLUSTER_RST: rd_mux = DATA_W'(VAL_CLUSTER_RST);
            RG_SYS_RST:     rd_mux = DATA_W'(VAL_SYS_RST);
            RG_CORE_RST:    rd_mux = DATA_W'(VAL_CORE_RST);
            RG_CORE_CTRL:   rd_mux = DATA_W'(VAL_CORE_CTRL);
            RG_CORE_STAT:   rd_mux = DATA_W'(VAL_CORE_STAT);
            RG_GATE:        rd_mux = DATA_W'(VAL_GATE);
            RG_GEN:         rd_mux = gen_q;
            RG_STBY:        rd_mux = stby_q;
            RG_ENTRY:       rd_mux = entry_q;
            default:        rd_mux = '0;
        endcase
    end

    // Response register: valid, data and error one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= rd_ok ? rd_mux : '0;
            rsp_err   <= req_valid && (!full_word || bad_target);
        end
    end

    assign start_el = START_EL;

    // R10: every request is answered in the next cycle, and only then.
    a_r10_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r10_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R9: a partial access is always flagged.
    a_r9_partial_err: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_be != {BE_W{1'b1}}) |=> rsp_err);
    // R4: a start pulse is always the echo of an accepted full-word write.
    a_r4_pulse_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req != '0) |-> $past(req_valid && req_write && req_be == {BE_W{1'b1}}));
    // R10: error and read data never coexist.
    a_r10_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_rdata == '0);

endmodule

// File: tb/cluster_cfg_regs_bench.sv
module cluster_cfg_regs_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [9:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = 4'hF;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic [3:0]  start_req;
    logic [31:0] start_addr;
    logic [1:0]  start_el;

    int checks = 0;
    int failures = 0;

    logic        c_valid;
    logic [31:0] c_rdata;
    logic        c_err;
    logic [3:0]  c_start;
    logic [31:0] c_addr;

    always #10 clk = ~clk;  // 50 MHz

    cluster_cfg_regs u_cluster_cfg_regs (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .start_req(start_req), .start_addr(start_addr), .start_el(start_el)
    );

    typedef struct packed {
        logic [15:0] tag;
        logic        we;
        logic [9:0]  addr;
        logic [31:0] wd;
        logic [3:0]  be;
        logic [31:0] rd;
        logic        err;
        logic [3:0]  st;
    } vec_t;

    localparam int NV = 34;
    localparam vec_t VEC [NV] = '{
        '{"R1", 1'b0, 10'h184, 32'h0, 4'hF, 32'h20, 1'b0, 4'h0},
        '{"R1", 1'b0, 10'h1A0, 32'h0, 4'hF, 32'h0, 1'b0, 4'h0},
        '{"R1", 1'b0, 10'h1A4, 32'h0, 4'hF, 32'h0, 1'b0, 4'h0},
        '{"R2", 1'b1, 10'h184, 32'hDEADBEEF, 4'hF, 32'h0, 1'b0, 4'h0},
        '{"R2", 1'b0, 10'h184, 32'h0, 4'hF, 32'hDEADBEEF, 1'b0, 4'h0},
        '{"R2", 1'b1, 10'h1A0, 32'h1, 4'hF, 32'h0, 1'b0, 4'h0},
        '{"R2", 1'b0, 10'h1A0, 32'h0, 4'hF, 32'h1, 1'b0, 4'h0},
        '{"R2", 1'b1, 10'h1A4, 32'h40008000, 4'hF, 32'h0, 1'b0, 4'h0},
        '{"R2", 1'b0, 10'h1A4, 32'h0, 4'hF, 32'h40008000, 1'b0, 4'h0},
        '{"R3", 1'b0, 10'h000, 32'h0, 4'hF, 32'h1, 1'b0, 4'h0},
        '{"R3", 1'b0, 10'h140, 32'h0, 4'hF, 32'h1, 1'b0, 4'h0},
        '{"R3", 1'b0, 10'h040, 32'h0, 4'hF, 32'h3, 1'b0, 4'h0},
        '{"R3", 1'b0, 10'h0C4, 32'h0, 4'hF, 32'h0, 1'b0, 4'h0},
        '{"R3", 1'b0, 10'h108, 32'h0, 4'hF, 32'h1, 1'b0, 4'h0},
        '{"R3", 1'b1, 10'h144, 32'h0, 4'hF, 32'h0, 1'b0, 4'h0},
        '{"R3", 1'b0, 10'h144, 32'h0, 4'hF, 32'h10F, 1'b0, 4'h0},
        '{"R3", 1'b1, 10'h048, 32'hFFFF, 4'hF, 32'h0, 1'b0, 4'h0},
        '{"R3", 1'b0, 10'h048, 32'h0, 4'hF, 32'h1, 1'b0, 4'h0},
        '{"R4", 1'b1, 10'h080, 32'h1, 4'hF, 32'h0, 1'b0, 4'h2},
        '{"R4", 1'b1, 10'h100, 32'h5, 4'hF, 32'h0, 1'b0, 4'h8},
        '{"R6", 1'b1, 10'h040, 32'h0, 4'hF, 32'h0, 1'b0, 4'h0},
        '{"R4", 1'b1, 10'h0C0, 32'h80000000, 4'hF, 32'h0, 1'b0, 4'h4},
        '{"R7", 1'b0, 10'h1E4, 32'h0, 4'hF, 32'h0, 1'b1, 4'h0},
        '{"R7", 1'b1, 10'h280, 32'h1234, 4'hF, 32'h0, 1'b1, 4'h0},
        '{"R7", 1'b0, 10'h280, 32'h0, 4'hF, 32'h0, 1'b1, 4'h0},
        '{"R7", 1'b0, 10'h288, 32'h0, 4'hF, 32'h0, 1'b1, 4'h0},
        '{"R8", 1'b0, 10'h3FC, 32'h0, 4'hF, 32'h0, 1'b1, 4'h0},
        '{"R8", 1'b0, 10'h186, 32'h0, 4'hF, 32'h0, 1'b1, 4'h0},
        '{"R8", 1'b0, 10'h04C, 32'h0, 4'hF, 32'h0, 1'b1, 4'h0},
        '{"R8", 1'b1, 10'h041, 32'h1, 4'hF, 32'h0, 1'b1, 4'h0},
        '{"R9", 1'b1, 10'h184, 32'h11111111, 4'h3, 32'h0, 1'b1, 4'h0},
        '{"R9", 1'b0, 10'h184, 32'h0, 4'hF, 32'hDEADBEEF, 1'b0, 4'h0},
        '{"R9", 1'b1, 10'h040, 32'h1, 4'h1, 32'h0, 1'b1, 4'h0},
        '{"R9", 1'b0, 10'h184, 32'h0, 4'h7, 32'h0, 1'b1, 4'h0}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    // One request cycle; outputs captured just after the answering edge.
    task automatic access(input logic we, input logic [9:0] a,
                          input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        req_valid = 1'b1; req_write = we; req_addr = a; req_wdata = d; req_be = be;
        @(posedge clk); #1;
        c_valid = rsp_valid; c_rdata = rsp_rdata; c_err = rsp_err;
        c_start = start_req; c_addr = start_addr;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset state of the outputs
        check("R1", "rsp_valid after reset", 32'(rsp_valid), 32'h0);
        check("R1", "start_req after reset", 32'(start_req), 32'h0);
        check("R5", "start_el", 32'(start_el), 32'h3);

        for (int i = 0; i < NV; i++) begin
            access(VEC[i].we, VEC[i].addr, VEC[i].wd, VEC[i].be);
            check(string'(VEC[i].tag), $sformatf("vec %0d rdata", i), c_rdata, VEC[i].rd);
            check(string'(VEC[i].tag), $sformatf("vec %0d err", i), 32'(c_err), 32'(VEC[i].err));
            check(string'(VEC[i].tag), $sformatf("vec %0d start_req", i), 32'(c_start), 32'(VEC[i].st));
            check("R10", $sformatf("vec %0d rsp_valid", i), 32'(c_valid), 32'h1);
        end

        // R10: idle cycle gives no response and no pulse
        @(posedge clk); #1;
        check("R10", "idle rsp_valid", 32'(rsp_valid), 32'h0);

        // R5: the pulse carries the freshly written entry address
        access(1'b1, 10'h1A4, 32'h12345678, 4'hF);
        access(1'b1, 10'h0C0, 32'h00000010, 4'hF);
        check("R4", "core2 pulse", 32'(c_start), 32'h4);
        check("R5", "start_addr", c_addr, 32'h12345678);
        check("R5", "start_el in pulse", 32'(start_el), 32'h3);
        @(posedge clk); #1;
        check("R4", "pulse width one cycle", 32'(start_req), 32'h0);

        // R10: a read of a reset register does not start the core
        access(1'b0, 10'h100, 32'h0, 4'hF);
        check("R10", "read no pulse", 32'(c_start), 32'h0);
        check("R3", "core3 reset reads 3", c_rdata, 32'h3);

        // R1: mid-run reset restores defaults
        access(1'b1, 10'h184, 32'hA5A5A5A5, 4'hF);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        access(1'b0, 10'h184, 32'h0, 4'hF);
        check("R1", "gen after re-reset", c_rdata, 32'h20);
        access(1'b0, 10'h1A4, 32'h0, 4'hF);
        check("R1", "entry after re-reset", c_rdata, 32'h0);

        finish_run();
    end

endmodule